// File: doc/BRIEF.md
# Pixel Output Formatter

This block is the last digital stage behind a pixel converter. It accepts one 12-bit pixel sample per data-clock cycle, together with a blanking strobe and a black-clamp window strobe. It delivers the finished 12-bit output word a fixed number of data-clock cycles later. On the way it can replace blanked pixels with zero or with the programmed clamp level. The clamp window overrides blanking. The word can then be recoded to Gray code, and the result is shown either through an output register or through a transparent path. A separate drive-enable pin tells the pad ring whether to float the bus.

The whole block runs on a fast system clock `clk`. The data clock arrives as a level input that is synchronous to `clk`. A data-clock cycle is the `clk` edge at which the data clock is first seen at its active level. The pixel stream has no valid/ready handshake. The source presents one sample per data-clock cycle and cannot be held back, so there is no back-pressure. All configuration inputs are static levels driven by a register block outside this one.

Top module: `pix_out_fmt`

## Requirements
- R1: In registered mode, a pixel captured at data-clock edge k appears on `dout_o` right after edge k+9, and samples leave in the order they entered.
- R2: In registered mode, `dout_o` does not change between data-clock edges, even when `pix_i` changes.
- R3: A pixel captured with the blanking strobe active and the clamp window inactive is output as all zeros when `blank_to_clamp_i` is 0, whatever `gray_i` is.
- R4: When `blank_to_clamp_i` is 1, a blanked pixel is replaced by `clamp_lvl_i`, zero-extended in the low 8 bits of the 12-bit word.
- R5: If the clamp window is active in the same cycle as blanking, blanking has no effect and the captured pixel passes unchanged.
- R6: When `gray_i` is 1, the output is `w ^ (w >> 1)`, where w is the word after blank substitution. When `gray_i` is 0, the output is w in straight binary.
- R7: When `transparent_i` is 1, `dout_o` shows the formatted word one data-clock edge earlier than in registered mode, that is, right after edge k+8.
- R8: `dout_en_o` is 0 while `hiz_i` is 1 and 1 while `hiz_i` is 0.
- R9: For each of `dclk_i`, `clamp_win_i` and `blank_i`, the matching polarity bit selects the active level: 1 means active high and 0 means active low. A data-clock edge is the change to the active level.
- R10: During reset and after it, until nine data-clock edges have passed, `dout_o` is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dclk_i | input | 1 | Data clock level, synchronous to clk |
| pix_i | input | 12 | Converted pixel sample |
| blank_i | input | 1 | Blanking strobe |
| clamp_win_i | input | 1 | Black-clamp window strobe |
| pol_dclk_i | input | 1 | Data clock polarity (1 = active high) |
| pol_clamp_i | input | 1 | Clamp window polarity (1 = active high) |
| pol_blank_i | input | 1 | Blanking polarity (1 = active high) |
| blank_to_clamp_i | input | 1 | Blank fill: 0 = zeros, 1 = clamp level |
| clamp_lvl_i | input | 8 | Clamp level used as blank fill |
| gray_i | input | 1 | Output coding: 0 = binary, 1 = Gray |
| transparent_i | input | 1 | Output path: 0 = registered, 1 = transparent |
| hiz_i | input | 1 | Float the data bus when 1 |
| dout_o | output | 12 | Formatted output word |
| dout_en_o | output | 1 | Bus drive enable for the pad ring |

## Verification
The bench builds the block with the default latency of nine. It therefore checks the exact alignment: a marker pixel is compared at every data-clock edge, and so an off-by-one in either direction shows up. The same stimulus table is walked under four configuration sets. Together these sets cover both polarities of every strobe, both blank fills, both codings and both output paths, including a Gray-coded zero blank and a clamp window that overlaps blanking.

// File: rtl/pof_pkg.sv
package pof_pkg;
  localparam int unsigned PIX_W = 12;
  localparam int unsigned CLV_W = 8;

  typedef struct packed {
    logic [PIX_W-1:0] pix;
    logic             blank;
  } pof_beat_t;

  typedef enum logic {
    OUT_REGISTERED  = 1'b0,
    OUT_TRANSPARENT = 1'b1
  } pof_outmode_e;

  function automatic logic [PIX_W-1:0] to_gray(input logic [PIX_W-1:0] b);
    return b ^ (b >> 1);
  endfunction
endpackage

// File: rtl/pof_edge_qual.sv
module pof_edge_qual (
  input  logic clk,
  input  logic rst_n,
  input  logic dclk_i,
  input  logic pol_dclk_i,
  input  logic clamp_i,
  input  logic pol_clamp_i,
  input  logic blank_i,
  input  logic pol_blank_i,
  output logic adv_o,
  output logic clamp_act_o,
  output logic blank_act_o
);
  logic dclk_eff;
  logic dclk_q;

  always_comb begin
    dclk_eff    = pol_dclk_i  ? dclk_i  : ~dclk_i;
    clamp_act_o = pol_clamp_i ? clamp_i : ~clamp_i;
    blank_act_o = pol_blank_i ? blank_i : ~blank_i;
    adv_o       = dclk_eff & ~dclk_q;
  end

  // reset high so that a clock already at its active level is not taken as an edge
  always_ff @(posedge clk) begin
    if (!rst_n) dclk_q <= 1'b1;
    else        dclk_q <= dclk_eff;
  end

  AST_EDGE_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
    adv_o |=> !adv_o); // R9
endmodule

// File: rtl/pof_delay_line.sv
module pof_delay_line
  import pof_pkg::*;
#(
  parameter int unsigned DEPTH = 9
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      adv_i,
  input  pof_beat_t beat_i,
  output pof_beat_t beat_o
);
  pof_beat_t stg [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n)     stg[0] <= '0;
    else if (adv_i) stg[0] <= beat_i;
  end

  for (genvar i = 1; i < DEPTH; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n)     stg[i] <= '0;
      else if (adv_i) stg[i] <= stg[i-1];
    end
  end

  assign beat_o = stg[DEPTH-1];

  AST_LINE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !adv_i |=> $stable(beat_o)); // R1

  if (DEPTH > 1) begin : g_shift_chk
    AST_LINE_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
      adv_i |=> stg[1] == $past(stg[0])); // R1
  end
endmodule

// File: rtl/pof_fmt_stage.sv
module pof_fmt_stage
  import pof_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv_i,
  input  pof_beat_t        beat_i,
  input  logic             blank_to_clamp_i,
  input  logic [CLV_W-1:0] clamp_lvl_i,
  input  logic             gray_i,
  input  pof_outmode_e     mode_i,
  output logic [PIX_W-1:0] data_o
);
  logic [PIX_W-1:0] fill;
  logic [PIX_W-1:0] subst;
  logic [PIX_W-1:0] coded;
  logic [PIX_W-1:0] out_q;

  always_comb begin
    fill  = blank_to_clamp_i ? PIX_W'(clamp_lvl_i) : '0;
    subst = beat_i.blank ? fill : beat_i.pix;
    coded = gray_i ? to_gray(subst) : subst;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     out_q <= '0;
    else if (adv_i) out_q <= coded;
  end

  assign data_o = (mode_i == OUT_TRANSPARENT) ? coded : out_q;

  AST_ZERO_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_i.blank && !blank_to_clamp_i) |-> coded == '0); // R3

  AST_CLAMP_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_i.blank && blank_to_clamp_i && !gray_i) |-> coded == PIX_W'(clamp_lvl_i)); // R4

  AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !adv_i |=> $stable(out_q)); // R2
endmodule

// File: rtl/pix_out_fmt.sv
module pix_out_fmt
  import pof_pkg::*;
#(
  parameter int unsigned LATENCY = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dclk_i,
  input  logic [PIX_W-1:0] pix_i,
  input  logic             blank_i,
  input  logic             clamp_win_i,
  input  logic             pol_dclk_i,
  input  logic             pol_clamp_i,
  input  logic             pol_blank_i,
  input  logic             blank_to_clamp_i,
  input  logic [CLV_W-1:0] clamp_lvl_i,
  input  logic             gray_i,
  input  logic             transparent_i,
  input  logic             hiz_i,
  output logic [PIX_W-1:0] dout_o,
  output logic             dout_en_o
);
  // the capture register counts as the first of the stages ahead of the output latch
  localparam int unsigned STAGES = LATENCY;

  logic      adv;
  logic      clamp_act;
  logic      blank_act;
  pof_beat_t beat_in;
  pof_beat_t beat_out;

  pof_edge_qual u_qual (
    .clk         (clk),
    .rst_n       (rst_n),
    .dclk_i      (dclk_i),
    .pol_dclk_i  (pol_dclk_i),
    .clamp_i     (clamp_win_i),
    .pol_clamp_i (pol_clamp_i),
    .blank_i     (blank_i),
    .pol_blank_i (pol_blank_i),
    .adv_o       (adv),
    .clamp_act_o (clamp_act),
    .blank_act_o (blank_act)
  );

  // blanking is decided at capture, with the clamp window taking priority
  always_comb begin
    beat_in.pix   = pix_i;
    beat_in.blank = blank_act & ~clamp_act;
  end

  pof_delay_line #(.DEPTH(STAGES)) u_line (
    .clk    (clk),
    .rst_n  (rst_n),
    .adv_i  (adv),
    .beat_i (beat_in),
    .beat_o (beat_out)
  );

  pof_fmt_stage u_fmt (
    .clk              (clk),
    .rst_n            (rst_n),
    .adv_i            (adv),
    .beat_i           (beat_out),
    .blank_to_clamp_i (blank_to_clamp_i),
    .clamp_lvl_i      (clamp_lvl_i),
    .gray_i           (gray_i),
    .mode_i           (pof_outmode_e'(transparent_i)),
    .data_o           (dout_o)
  );

  assign dout_en_o = ~hiz_i;

  AST_CLAMP_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    clamp_act |-> !beat_in.blank); // R5
endmodule

// File: tb/pix_out_fmt_bench.sv
module pix_out_fmt_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        dclk = 1'b0;
  logic [11:0] pix = '0;
  logic        blank = 1'b0, clampw = 1'b0;
  logic        pol = 1'b1, b2c = 1'b0, gray = 1'b0, transp = 1'b0, hiz = 1'b0;
  logic [7:0]  clv = 8'h00;
  logic [11:0] dout;
  logic        den;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  pix_out_fmt u_pix_out_fmt (
    .clk(clk), .rst_n(rst_n), .dclk_i(dclk), .pix_i(pix),
    .blank_i(blank), .clamp_win_i(clampw),
    .pol_dclk_i(pol), .pol_clamp_i(pol), .pol_blank_i(pol),
    .blank_to_clamp_i(b2c), .clamp_lvl_i(clv), .gray_i(gray),
    .transparent_i(transp), .hiz_i(hiz), .dout_o(dout), .dout_en_o(den)
  );

  // {pixel, blank active, clamp window active}
  localparam int NV = 20;
  localparam logic [13:0] VEC [NV] = '{
    {12'h123, 2'b00}, {12'hFFF, 2'b00}, {12'h800, 2'b10}, {12'h7FF, 2'b11},
    {12'h001, 2'b01}, {12'hABC, 2'b00}, {12'h555, 2'b10}, {12'h0F0, 2'b00},
    {12'h3C3, 2'b11}, {12'hFED, 2'b00}, {12'h246, 2'b10}, {12'h999, 2'b00},
    {12'h000, 2'b00}, {12'h8A1, 2'b11}, {12'h444, 2'b10}, {12'h1E7, 2'b01},
    {12'hC00, 2'b00}, {12'h6B2, 2'b10}, {12'hF0F, 2'b00}, {12'h314, 2'b00}
  };

  function automatic logic [11:0] model(logic [13:0] v);
    logic [11:0] s;
    s = (v[1] && !v[0]) ? (b2c ? {4'h0, clv} : 12'h000) : v[13:2];
    return gray ? (s ^ (s >> 1)) : s;
  endfunction

  function automatic string tag_of(logic [13:0] v);
    string t;
    if (v[1] && !v[0])     t = b2c ? "R4" : "R3";
    else if (v[1] && v[0]) t = "R5";
    else                   t = "R1";
    if (gray)   t = {t, "/R6"};
    if (transp) t = {t, "/R7"};
    if (!pol)   t = {t, "/R9"};
    return t;
  endfunction

  task automatic check(string req, logic [11:0] act, logic [11:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic dtick(logic [11:0] p, logic b, logic c);
    @(negedge clk);
    pix = p; blank = pol ? b : ~b; clampw = pol ? c : ~c;
    dclk = pol;
    @(negedge clk);
    dclk = ~pol;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; dclk = ~pol; blank = ~pol; clampw = ~pol;
    repeat (3) @(negedge clk);
    check("R10 reset data", dout, 12'h000);
    check("R8 reset enable", {11'h0, den}, 12'h001);
    rst_n = 1'b1;
  endtask

  task automatic run_table(logic p, logic g, logic l, logic t, logic [7:0] c);
    int lat;
    pol = p; gray = g; b2c = l; transp = t; clv = c;
    do_reset();
    lat = t ? 8 : 9;
    for (int i = 0; i < NV + 9; i++) begin
      logic [13:0] v;
      int j;
      v = (i < NV) ? VEC[i] : 14'h0;
      dtick(v[13:2], v[1], v[0]);
      j = i - lat;
      if (j < 0) check("R10 early output", dout, 12'h000);
      else if (j < NV) check(tag_of(VEC[j]), dout, model(VEC[j]));
      else check("R1 flush", dout, 12'h000);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog R1 actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [11:0] held;
    run_table(1'b1, 1'b0, 1'b0, 1'b0, 8'h00);
    run_table(1'b0, 1'b1, 1'b1, 1'b0, 8'hA5);
    run_table(1'b1, 1'b0, 1'b1, 1'b1, 8'h3C);
    run_table(1'b0, 1'b1, 1'b0, 1'b1, 8'h7E);

    // R2: registered output holds while no data-clock edge arrives
    run_table(1'b1, 1'b0, 1'b0, 1'b0, 8'h00);
    for (int i = 0; i < 9; i++) dtick(12'hA00 + 12'(i), 1'b0, 1'b0);
    dtick(12'h5A5, 1'b0, 1'b0);
    held = dout;
    check("R2 value before hold", held, 12'hA00);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      pix = 12'(i * 311);
    end
    check("R2 held between edges", dout, held);

    // R9: inactive-going data clock transition is not an edge
    @(negedge clk); dclk = ~pol;
    @(negedge clk);
    check("R9 no edge on inactive level", dout, held);

    // R8: three-state control
    hiz = 1'b1; @(negedge clk);
    check("R8 float", {11'h0, den}, 12'h000);
    hiz = 1'b0; @(negedge clk);
    check("R8 drive", {11'h0, den}, 12'h001);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule